// File: doc/BRIEF.md
# Link-Path ROM Sequencer

This block is a table-driven sequential controller. A small state register, the external condition inputs (qualifiers) and a machine-select field are joined into one memory address. The word stored there carries the next state code together with the output pattern. Every control step writes that next state back into the register, where it becomes part of the following address, and registers the outputs. A different controller therefore needs only a different table. The logic stays the same.

The memory image is computed at elaboration by a package function, so no file is read. It holds one region for each selectable machine. Region 0 is a heater loop with a fault state. Region 1 is a four-position ring that advances on a condition. All other regions are left unprogrammed and read as zero. A parameter sets how many idle clocks pass between steps, and a stop input stalls the loop between steps.

Top module: `linkpath_sequencer`

## Requirements
- R1: The lookup address is {proc_sel, qual, present state}, with proc_sel as the most significant field and the state in the two lowest bits. Each address holds the word for one transition.
- R2: Bits [2:1] of the fetched word become the next state. The output pattern is {word[7:3], word[0]}, so ctrl_out[0] is word bit 0 and ctrl_out[5:1] are word bits 7..3.
- R3: The state register changes only on the apply clock of a step. The value it loads is used in the address of the next step.
- R4: When rst is high at a clock edge, state_out and ctrl_out are zero after that edge, and the next step starts with a fetch.
- R5: A step takes one fetch clock, where the address is sampled and the word is read, and then one apply clock, where state and outputs load. After that come CYCLE_GAP idle clocks. With the default of 0, one step completes every 2 clocks.
- R6: stop is sampled when a step would begin. While it is high, no fetch happens and state_out and ctrl_out hold.
- R7: If proc_sel at a fetch differs from the machine used by the previous step, that step loads state 0 and all-zero outputs.
- R8: Every address in regions 2 to 7 reads 0x00, which gives state 0 and all outputs low.
- R9: Region 0 uses qual[0] as the low-limit flag and qual[1] as the high-limit flag. In state 00 it goes to 01 on low. In state 01 it goes to 10 (fault) on low, otherwise to 11 (heating). In state 11 it goes to 00 on high, otherwise it stays. State 10 always goes to 00. ctrl_out[0] is high when the next state is 11, and ctrl_out[1] is high when the next state is 10.
- R10: Region 1 clears to state 0 when qual[1] is 1. Otherwise it adds 1 (mod 4) when qual[0] is 1 and holds when qual[0] is 0. ctrl_out[5:2] is the one-hot code of the next state, and ctrl_out[1:0] are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop | input | 1 | Stalls the step loop while high |
| proc_sel | input | 3 | Selects which machine region is addressed |
| qual | input | 2 | Condition inputs that form part of the address |
| ctrl_out | output | 6 | Registered output pattern from the last step |
| state_out | output | 2 | Registered present state |

## Verification
The bench walks both programmed machines through every transition. This includes the 3-to-0 wrap of the ring and a clear that overrides advance. A design that took the state from the wrong word bits, or fed back a stale state, would show a wrong sequence. Machine switches are tested in both directions and into an unprogrammed region. A design that kept the old state across a switch would land in a state of the other machine.

Stop is held through several clocks with qualifiers that would move the machine, and a mid-run reset is applied. A slow-paced instance is checked during its idle clocks. A design that ignored the gap, or let stop through mid-loop, would change state early.

// File: rtl/seqtab_pkg.sv
package seqtab_pkg;

  localparam int PROC_W    = 3;
  localparam int QUAL_W    = 2;
  localparam int STATE_W   = 2;
  localparam int WORD_W    = 8;
  localparam int PROGRAMMED = 2;  // regions 0 and 1 carry tables

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_APPLY = 2'd1,
    PH_WAIT  = 2'd2
  } phase_t;

  // Word layout: [7:4] ring one-hot, [3] fault lamp, [2:1] next state, [0] heater
  function automatic logic [7:0] image_word(input int unsigned addr);
    logic [31:0] a;
    logic [2:0]  pr;
    logic [1:0]  q;
    logic [1:0]  st;
    logic [1:0]  ns;
    logic [7:0]  w;
    a  = 32'(addr);
    pr = a[6:4];
    q  = a[3:2];
    st = a[1:0];
    ns = 2'b00;
    w  = 8'h00;
    if (pr == 3'd0) begin
      case (st)
        2'b00:   ns = q[0] ? 2'b01 : 2'b00;
        2'b01:   ns = q[0] ? 2'b10 : 2'b11;
        2'b11:   ns = q[1] ? 2'b00 : 2'b11;
        default: ns = 2'b00;
      endcase
      w = {4'b0000, (ns == 2'b10), ns, (ns == 2'b11)};
    end else if (pr == 3'd1) begin
      if (q[1])      ns = 2'b00;
      else if (q[0]) ns = st + 2'b01;
      else           ns = st;
      w = {(4'b0001 << ns), 1'b0, ns, 1'b0};
    end
    return w;
  endfunction

endpackage

// File: rtl/seqtab_rom.sv
module seqtab_rom #(
  parameter int PROC_W = seqtab_pkg::PROC_W,
  parameter int ADDR_W = 7,
  parameter int WORD_W = seqtab_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = WORD_W'(seqtab_pkg::image_word(i));
    end
  end

  // Registered read with enable: maps onto a block RAM output port
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[addr];
  end

  AST_UNPROG_ZERO: assert property (@(posedge clk)
    (rd_en && (int'(addr[ADDR_W-1 -: PROC_W]) >= seqtab_pkg::PROGRAMMED)) |=> (rd_data == '0)); // R8

endmodule

// File: rtl/seqtab_pacer.sv
module seqtab_pacer #(
  parameter int CYCLE_GAP = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  output logic fetch_en,
  output logic apply_en
);
  import seqtab_pkg::*;

  localparam int CNT_W = (CYCLE_GAP > 1) ? $clog2(CYCLE_GAP) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = (CYCLE_GAP > 0) ? CNT_W'(CYCLE_GAP - 1) : '0;

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FETCH;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_FETCH: if (!stop) phase_q <= PH_APPLY;
        PH_APPLY: begin
          if (CYCLE_GAP == 0) begin
            phase_q <= PH_FETCH;
          end else begin
            phase_q <= PH_WAIT;
            cnt_q   <= CNT_LOAD;
          end
        end
        PH_WAIT: begin
          if (cnt_q == '0) phase_q <= PH_FETCH;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_FETCH;
      endcase
    end
  end

  assign fetch_en = (phase_q == PH_FETCH) && !stop;
  assign apply_en = (phase_q == PH_APPLY);

  AST_APPLY_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (rst)
    fetch_en |=> apply_en); // R5

  generate
    if (CYCLE_GAP == 0) begin : g_tight
      AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        apply_en |=> (fetch_en || stop)); // R5
    end else begin : g_gap
      AST_GAP_RESPECTED: assert property (@(posedge clk) disable iff (rst)
        apply_en |=> !fetch_en); // R5
    end
  endgenerate

endmodule

// File: rtl/seqtab_core.sv
module seqtab_core #(
  parameter int PROC_W  = seqtab_pkg::PROC_W,
  parameter int STATE_W = seqtab_pkg::STATE_W,
  parameter int WORD_W  = seqtab_pkg::WORD_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fetch_en,
  input  logic                      apply_en,
  input  logic [PROC_W-1:0]         proc_sel,
  input  logic [WORD_W-1:0]         rd_word,
  output logic [STATE_W-1:0]        state_q,
  output logic [WORD_W-STATE_W-1:0] out_q
);
  localparam int OUT_W = WORD_W - STATE_W;

  logic [PROC_W-1:0]  proc_q;     // machine used by the last applied step
  logic [PROC_W-1:0]  pend_proc_q;
  logic               sw_q;
  logic [STATE_W-1:0] link_part;
  logic [OUT_W-1:0]   instr_part;

  assign link_part  = rd_word[STATE_W:1];
  assign instr_part = {rd_word[WORD_W-1:STATE_W+1], rd_word[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= '0;
      out_q       <= '0;
      proc_q      <= '0;
      pend_proc_q <= '0;
      sw_q        <= 1'b0;
    end else begin
      if (fetch_en) begin
        pend_proc_q <= proc_sel;
        sw_q        <= (proc_sel != proc_q);
      end
      if (apply_en) begin
        proc_q <= pend_proc_q;
        if (sw_q) begin
          state_q <= '0;
          out_q   <= '0;
        end else begin
          state_q <= link_part;
          out_q   <= instr_part;
        end
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (state_q == '0 && out_q == '0)); // R4

  AST_HOLD_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (rst)
    !apply_en |=> ($stable(state_q) && $stable(out_q))); // R3

  AST_LOAD_LINK: assert property (@(posedge clk) disable iff (rst)
    (apply_en && !sw_q) |=> (state_q == $past(rd_word[STATE_W:1]))); // R2

  AST_SWITCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (apply_en && pend_proc_q != proc_q) |=> (state_q == '0 && out_q == '0)); // R7

endmodule

// File: rtl/linkpath_sequencer.sv
module linkpath_sequencer #(
  parameter int PROC_W    = seqtab_pkg::PROC_W,
  parameter int QUAL_W    = seqtab_pkg::QUAL_W,
  parameter int STATE_W   = seqtab_pkg::STATE_W,
  parameter int WORD_W    = seqtab_pkg::WORD_W,
  parameter int CYCLE_GAP = 0,
  localparam int ADDR_W   = PROC_W + QUAL_W + STATE_W,
  localparam int OUT_W    = WORD_W - STATE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stop,
  input  logic [PROC_W-1:0]  proc_sel,
  input  logic [QUAL_W-1:0]  qual,
  output logic [OUT_W-1:0]   ctrl_out,
  output logic [STATE_W-1:0] state_out
);
  logic              fetch_en;
  logic              apply_en;
  logic [ADDR_W-1:0] lookup_addr;
  logic [WORD_W-1:0] word;

  // Machine select on top, qualifiers next, present state lowest
  assign lookup_addr = {proc_sel, qual, state_out};

  seqtab_pacer #(.CYCLE_GAP(CYCLE_GAP)) u_pacer (
    .clk      (clk),
    .rst      (rst),
    .stop     (stop),
    .fetch_en (fetch_en),
    .apply_en (apply_en)
  );

  seqtab_rom #(.PROC_W(PROC_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rom (
    .clk     (clk),
    .rd_en   (fetch_en),
    .addr    (lookup_addr),
    .rd_data (word)
  );

  seqtab_core #(.PROC_W(PROC_W), .STATE_W(STATE_W), .WORD_W(WORD_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .fetch_en (fetch_en),
    .apply_en (apply_en),
    .proc_sel (proc_sel),
    .rd_word  (word),
    .state_q  (state_out),
    .out_q    (ctrl_out)
  );

  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (stop && !apply_en) |=> ($stable(state_out) && $stable(ctrl_out))); // R6

endmodule

// File: tb/linkpath_sequencer_test.sv
module linkpath_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  // {proc_sel[2:0], qual[1:0], expected state[1:0], expected ctrl_out[5:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd0, 2'b00, 2'b00, 6'b000000},  // R9 idle holds
    {3'd0, 2'b01, 2'b01, 6'b000000},  // R9 low -> check
    {3'd0, 2'b00, 2'b11, 6'b000001},  // R9 heat
    {3'd0, 2'b00, 2'b11, 6'b000001},  // R9 keep heating
    {3'd0, 2'b10, 2'b00, 6'b000000},  // R9 high -> idle
    {3'd0, 2'b01, 2'b01, 6'b000000},
    {3'd0, 2'b01, 2'b10, 6'b000010},  // R9 fault
    {3'd0, 2'b11, 2'b00, 6'b000000},  // R9 fault exits always
    {3'd1, 2'b01, 2'b00, 6'b000000},  // R7 switch step
    {3'd1, 2'b01, 2'b01, 6'b001000},  // R10 advance
    {3'd1, 2'b00, 2'b01, 6'b001000},  // R10 hold
    {3'd1, 2'b01, 2'b10, 6'b010000},
    {3'd1, 2'b01, 2'b11, 6'b100000},
    {3'd1, 2'b01, 2'b00, 6'b000100},  // R10 wrap
    {3'd1, 2'b01, 2'b01, 6'b001000},
    {3'd1, 2'b11, 2'b00, 6'b000100},  // R10 clear wins
    {3'd5, 2'b01, 2'b00, 6'b000000},  // R7 switch into empty region
    {3'd5, 2'b01, 2'b00, 6'b000000},  // R8 unprogrammed word
    {3'd0, 2'b01, 2'b00, 6'b000000},  // R7 switch back
    {3'd0, 2'b01, 2'b01, 6'b000000}   // R1 R3 fresh start
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stop = 1'b0;
  logic [2:0] proc_sel = 3'd0;
  logic [1:0] qual = 2'b00;
  logic [5:0] ctrl_out, slow_out;
  logic [1:0] state_out, slow_state;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  linkpath_sequencer uut (
    .clk(clk), .rst(rst), .stop(stop), .proc_sel(proc_sel), .qual(qual),
    .ctrl_out(ctrl_out), .state_out(state_out)
  );

  linkpath_sequencer #(.CYCLE_GAP(2)) uut_slow (
    .clk(clk), .rst(rst), .stop(stop), .proc_sel(proc_sel), .qual(qual),
    .ctrl_out(slow_out), .state_out(slow_state)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // One step at the default pace: fetch edge, apply edge, sample at the falling edge
  task automatic run_step();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 reset state", {state_out, ctrl_out}, 8'h00);
    check("R4 reset state slow", {slow_state, slow_out}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      proc_sel = VEC[i][12:10];
      qual     = VEC[i][9:8];
      run_step();
      check($sformatf("R1 R2 R3 R7 R8 R9 R10 vector %0d", i),
            {state_out, ctrl_out}, VEC[i][7:0]);
    end

    // R6: stop held while qualifiers would force a fault
    stop = 1'b1;
    qual = 2'b01;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R6 stop holds", {state_out, ctrl_out}, {2'b01, 6'b000000});
    stop = 1'b0;
    qual = 2'b00;
    run_step();
    check("R6 resume after stop", {state_out, ctrl_out}, {2'b11, 6'b000001});

    // R4: reset in the middle of a run
    do_reset();
    check("R4 mid-run reset", {state_out, ctrl_out}, 8'h00);

    // R5: pacing, default and with two idle clocks
    proc_sel = 3'd0;
    qual = 2'b01;
    run_step();
    check("R5 slow first step", {6'b0, slow_state}, 8'h01);
    qual = 2'b00;
    run_step();
    check("R5 default pace second step", {state_out, ctrl_out}, {2'b11, 6'b000001});
    check("R5 slow still idle", {6'b0, slow_state}, 8'h01);
    @(posedge clk);
    @(negedge clk);
    check("R5 slow fetch only", {6'b0, slow_state}, 8'h01);
    @(posedge clk);
    @(negedge clk);
    check("R5 slow second step", {slow_state, slow_out}, {2'b11, 6'b000001});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule